// File: doc/BRIEF.md
# Two-Channel Converter Command and Power Controller

This block sits behind the serial front end of a two-channel 10-bit converter. It takes each 16-bit command word once the shifter has gathered it and signals it valid. It keeps every piece of digital state the converter needs. Each channel has a staging register and a live register, which together form a double buffer. Each channel also has a shutdown flag and a latch that selects its load while shut down. The block also holds a bias power-down flag and the edge-select bit for the serial read-back output.

Three pins act on the state directly. A load pin copies the staging registers into the live registers. A clear pin forces every code register to a value that a reset-value pin chooses. A lockout pin blocks shutdown commands, and its falling edge wakes everything. Shutdown never alters a stored code, so a woken channel drives the code it held before.

Top module: `dual_dac_regctl`

## Requirements
- R1: A word is bits [15:13] opcode, [12:3] data (bit 12 is the data MSB), and [2:0] a tail field. A valid word whose tail field is not zero changes nothing.
- R2: Opcode 001 writes the data to channel A's staging register, and 101 writes it to channel B's. Neither write changes a live code.
- R3: Opcode 010 writes staging A, and 110 writes staging B. Each then copies both staging registers into both live registers. Opcode 011 writes the data to all four registers. All three wake both channels.
- R4: Opcode 100 copies both staging registers to the live registers and wakes both channels. With opcode 000, data bits [9:7] = 001 do this for channel A only, and [9:7] = 101 for channel B only. The other channel's shutdown state is kept.
- R5: Opcode 111 shuts down both channels, taking the load select of A from data bit 9 and of B from data bit 8. Opcode 000 with [9:7] = 110 shuts down A with load select from bit 6. Opcode 000 with [9:7] = 111 shuts down B with load select from bit 5. A load select of 1 means the high-impedance load. Codes are kept through shutdown.
- R6: Opcode 000 with [9:7] = 011 is full power-down. It clears bias_en and shuts down A and B with load selects from bits 6 and 5. Any later update that wakes a channel sets bias_en again.
- R7: Opcode 000 with data [9:6] = 1001 sets dout_mode to 1, and [9:6] = 1000 sets it to 0.
- R8: While clear_n is low, every staging and live code equals 0x200 if rst_mid is high and 0 if it is low, with no clock edge needed. Shutdown, bias and mode state are untouched.
- R9: While load_n is low, each live code follows its staging register, starting before the next clock edge. A staging write made in a cycle where load_n is low reaches the live code. A channel that is shut down stays shut down.
- R10: While lock_n is low, shutdown and power-down commands are ignored. A falling edge of lock_n wakes both channels and the bias, and the codes held before the shutdown are kept.
- R11: After reset, both codes equal the rst_mid reset value, both channels are awake, bias_en is 1 and dout_mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_word | input | 16 | Command word from the serial shifter |
| cmd_valid | input | 1 | One-cycle strobe marking cmd_word |
| load_n | input | 1 | Level load of live registers, active low |
| clear_n | input | 1 | Asynchronous clear of all codes, active low |
| rst_mid | input | 1 | Reset/clear value select: 1 midscale, 0 zero |
| lock_n | input | 1 | Shutdown lockout, active low |
| code_a | output | 10 | Live code of channel A |
| code_b | output | 10 | Live code of channel B |
| sd_a | output | 1 | Channel A shut down |
| sd_b | output | 1 | Channel B shut down |
| hiz_a | output | 1 | Channel A shutdown load select (1 high impedance) |
| hiz_b | output | 1 | Channel B shutdown load select |
| bias_en | output | 1 | Bias and reference enabled |
| dout_mode | output | 1 | Read-back output edge select |

## Verification
The checks assume that rst_mid stays stable while clear_n is low. The clear captures the value on the falling edge of clear_n, so rst_mid is set before clear_n falls and is changed only after clear_n rises. The assertions also assume that lock_n and load_n are already synchronous to clk. The stimulus therefore drives these pins and the command strobe only on falling clock edges, one valid word at a time. The no-effect checks for the tail field and for lockout are observed at the flags and codes in the cycle after the word is given.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
   localparam int CH_A = 0;
   localparam int CH_B = 1;

   localparam logic [2:0] OP_EXT      = 3'b000;
   localparam logic [2:0] OP_WR_A     = 3'b001;
   localparam logic [2:0] OP_WR_A_UPD = 3'b010;
   localparam logic [2:0] OP_WR_ALL   = 3'b011;
   localparam logic [2:0] OP_UPD_ALL  = 3'b100;
   localparam logic [2:0] OP_WR_B     = 3'b101;
   localparam logic [2:0] OP_WR_B_UPD = 3'b110;
   localparam logic [2:0] OP_SD_ALL   = 3'b111;

   typedef struct packed {
      logic wr_in;
      logic upd;
      logic sd_set;
      logic sd_hiz;
   } ch_ctl_t;
endpackage

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
   import dual_dac_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CTRL_W = 3,
   parameter int SUB_W  = 3,
   parameter int NUM_CH = 2,
   localparam int WORD_W = CTRL_W + DATA_W + SUB_W
)(
   input  logic [WORD_W-1:0]      word,
   input  logic                   valid,
   input  logic                   sd_allow,
   output ch_ctl_t [NUM_CH-1:0]   ctl,
   output logic [DATA_W-1:0]      data,
   output logic                   pd_set,
   output logic                   mode_set,
   output logic                   mode_val
);
   logic [CTRL_W-1:0] op;
   logic [SUB_W-1:0]  tail;
   logic [3:0]        ext;
   logic              ok;

   assign op   = word[WORD_W-1 -: CTRL_W];
   assign data = word[SUB_W +: DATA_W];
   assign tail = word[SUB_W-1:0];
   assign ext  = data[DATA_W-1 -: 4];
   assign ok   = valid && (tail == '0);

   always_comb begin
      ctl      = '0;
      pd_set   = 1'b0;
      mode_set = 1'b0;
      mode_val = 1'b0;
      if (ok) begin
         unique case (op)
            OP_WR_A: ctl[CH_A].wr_in = 1'b1;
            OP_WR_B: ctl[CH_B].wr_in = 1'b1;
            OP_WR_A_UPD: begin
               ctl[CH_A].wr_in = 1'b1;
               ctl[CH_A].upd   = 1'b1;
               ctl[CH_B].upd   = 1'b1;
            end
            OP_WR_B_UPD: begin
               ctl[CH_B].wr_in = 1'b1;
               ctl[CH_A].upd   = 1'b1;
               ctl[CH_B].upd   = 1'b1;
            end
            OP_WR_ALL: begin
               ctl[CH_A].wr_in = 1'b1;
               ctl[CH_B].wr_in = 1'b1;
               ctl[CH_A].upd   = 1'b1;
               ctl[CH_B].upd   = 1'b1;
            end
            OP_UPD_ALL: begin
               ctl[CH_A].upd = 1'b1;
               ctl[CH_B].upd = 1'b1;
            end
            OP_SD_ALL: begin
               if (sd_allow) begin
                  ctl[CH_A].sd_set = 1'b1;
                  ctl[CH_A].sd_hiz = data[DATA_W-1];
                  ctl[CH_B].sd_set = 1'b1;
                  ctl[CH_B].sd_hiz = data[DATA_W-2];
               end
            end
            default: begin
               casez (ext)
                  4'b001?: ctl[CH_A].upd = 1'b1;
                  4'b101?: ctl[CH_B].upd = 1'b1;
                  4'b011?: begin
                     if (sd_allow) begin
                        pd_set           = 1'b1;
                        ctl[CH_A].sd_set = 1'b1;
                        ctl[CH_A].sd_hiz = data[DATA_W-4];
                        ctl[CH_B].sd_set = 1'b1;
                        ctl[CH_B].sd_hiz = data[DATA_W-5];
                     end
                  end
                  4'b110?: begin
                     if (sd_allow) begin
                        ctl[CH_A].sd_set = 1'b1;
                        ctl[CH_A].sd_hiz = data[DATA_W-4];
                     end
                  end
                  4'b111?: begin
                     if (sd_allow) begin
                        ctl[CH_B].sd_set = 1'b1;
                        ctl[CH_B].sd_hiz = data[DATA_W-5];
                     end
                  end
                  4'b1000: mode_set = 1'b1;
                  4'b1001: begin
                     mode_set = 1'b1;
                     mode_val = 1'b1;
                  end
                  default: ;
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/dual_dac_channel.sv
module dual_dac_channel
   import dual_dac_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter bit LOAD_BYPASS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              code_arst_n,
   input  logic [DATA_W-1:0] rst_val,
   input  ch_ctl_t           ctl,
   input  logic [DATA_W-1:0] data,
   input  logic              wake_all,
   input  logic              load_n,
   output logic [DATA_W-1:0] code,
   output logic              sd,
   output logic              hiz
);
   logic [DATA_W-1:0] in_q, out_q, in_nx, out_nx;

   assign in_nx  = ctl.wr_in ? data : in_q;
   assign out_nx = (ctl.upd || !load_n) ? in_nx : out_q;

   always_ff @(posedge clk or negedge code_arst_n) begin
      if (!code_arst_n) begin
         in_q  <= rst_val;
         out_q <= rst_val;
      end else begin
         in_q  <= in_nx;
         out_q <= out_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd  <= 1'b0;
         hiz <= 1'b0;
      end else if (ctl.upd || wake_all) begin
         sd  <= 1'b0;
      end else if (ctl.sd_set) begin
         sd  <= 1'b1;
         hiz <= ctl.sd_hiz;
      end
   end

   generate
      if (LOAD_BYPASS) begin : g_bypass
         assign code = load_n ? out_q : in_q;
      end else begin : g_registered
         assign code = out_q;
      end
   endgenerate
endmodule

// File: rtl/dual_dac_power.sv
module dual_dac_power (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_n,
   input  logic pd_set,
   input  logic upd_any,
   input  logic mode_set,
   input  logic mode_val,
   output logic wake_all,
   output logic bias_en,
   output logic dout_mode
);
   logic lock_q, pd_q;

   assign wake_all = lock_q && !lock_n;
   assign bias_en  = !pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q    <= 1'b1;
         pd_q      <= 1'b0;
         dout_mode <= 1'b0;
      end else begin
         lock_q <= lock_n;
         if (upd_any || wake_all) pd_q <= 1'b0;
         else if (pd_set)         pd_q <= 1'b1;
         if (mode_set) dout_mode <= mode_val;
      end
   end
endmodule

// File: rtl/dual_dac_regctl.sv
module dual_dac_regctl
   import dual_dac_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int CTRL_W      = 3,
   parameter int SUB_W       = 3,
   parameter int NUM_CH      = 2,
   parameter bit LOAD_BYPASS = 1'b1,
   localparam int WORD_W = CTRL_W + DATA_W + SUB_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic              cmd_valid,
   input  logic              load_n,
   input  logic              clear_n,
   input  logic              rst_mid,
   input  logic              lock_n,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b,
   output logic              sd_a,
   output logic              sd_b,
   output logic              hiz_a,
   output logic              hiz_b,
   output logic              bias_en,
   output logic              dout_mode
);
   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

   if (NUM_CH != 2) begin : g_bad_ch
      $error("command set addresses exactly two channels");
   end
   if (CTRL_W != 3) begin : g_bad_ctrl
      $error("opcode field must be three bits");
   end
   if (DATA_W < 6) begin : g_bad_data
      $error("data field too narrow for extended opcodes");
   end

   ch_ctl_t [NUM_CH-1:0]      ctl;
   logic [DATA_W-1:0]         data;
   logic                      pd_set, mode_set, mode_val, wake_all, upd_any;
   logic                      code_arst_n;
   logic [DATA_W-1:0]         rst_val;
   logic [NUM_CH-1:0][DATA_W-1:0] code_v;
   logic [NUM_CH-1:0]         sd_v, hiz_v;

   assign code_arst_n = rst_n && clear_n;
   assign rst_val     = rst_mid ? MID : '0;

   dual_dac_decode #(
      .DATA_W(DATA_W), .CTRL_W(CTRL_W), .SUB_W(SUB_W), .NUM_CH(NUM_CH)
   ) u_dec (
      .word(cmd_word), .valid(cmd_valid), .sd_allow(lock_n),
      .ctl(ctl), .data(data), .pd_set(pd_set),
      .mode_set(mode_set), .mode_val(mode_val)
   );

   always_comb begin
      upd_any = 1'b0;
      for (int i = 0; i < NUM_CH; i++) upd_any |= ctl[i].upd;
   end

   dual_dac_power u_pwr (
      .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .pd_set(pd_set),
      .upd_any(upd_any), .mode_set(mode_set), .mode_val(mode_val),
      .wake_all(wake_all), .bias_en(bias_en), .dout_mode(dout_mode)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      dual_dac_channel #(.DATA_W(DATA_W), .LOAD_BYPASS(LOAD_BYPASS)) u_ch (
         .clk(clk), .rst_n(rst_n), .code_arst_n(code_arst_n),
         .rst_val(rst_val), .ctl(ctl[g]), .data(data),
         .wake_all(wake_all), .load_n(load_n),
         .code(code_v[g]), .sd(sd_v[g]), .hiz(hiz_v[g])
      );
   end

   assign code_a = code_v[CH_A];
   assign code_b = code_v[CH_B];
   assign sd_a   = sd_v[CH_A];
   assign sd_b   = sd_v[CH_B];
   assign hiz_a  = hiz_v[CH_A];
   assign hiz_b  = hiz_v[CH_B];
endmodule

// File: rtl/dual_dac_regctl_chk.sv
module dual_dac_regctl_chk #(
   parameter int DATA_W = 10,
   parameter int SUB_W  = 3,
   parameter int WORD_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] cmd_word,
   input logic              cmd_valid,
   input logic              clear_n,
   input logic              rst_mid,
   input logic              lock_n,
   input logic [DATA_W-1:0] code_a,
   input logic [DATA_W-1:0] code_b,
   input logic              sd_a,
   input logic              sd_b,
   input logic              bias_en,
   input logic              dout_mode
);
   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);
   localparam logic [WORD_W-1:0] MODE1_WORD =
      WORD_W'(10'b1001000000) << SUB_W;

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_n |-> (code_a == (rst_mid ? MID : '0)) &&
                   (code_b == (rst_mid ? MID : '0)));

   p_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_n |=> (!sd_a && !sd_b));

   p_tail_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_word[SUB_W-1:0] != '0) && lock_n) |=>
      ($stable(dout_mode) && $stable(bias_en) && $stable(sd_a) && $stable(sd_b)));

   p_pd_both_sd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bias_en |-> (sd_a && sd_b));

   p_mode_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_word == MODE1_WORD) |=> dout_mode);
endmodule

bind dual_dac_regctl dual_dac_regctl_chk #(
   .DATA_W(DATA_W), .SUB_W(SUB_W), .WORD_W(WORD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
   .clear_n(clear_n), .rst_mid(rst_mid), .lock_n(lock_n),
   .code_a(code_a), .code_b(code_b), .sd_a(sd_a), .sd_b(sd_b),
   .bias_en(bias_en), .dout_mode(dout_mode)
);

// File: tb/dual_dac_regctl_test.sv
module dual_dac_regctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        cmd_valid = 1'b0;
   logic        load_n = 1'b1;
   logic        clear_n = 1'b1;
   logic        rst_mid = 1'b0;
   logic        lock_n = 1'b1;
   logic [9:0]  code_a, code_b;
   logic        sd_a, sd_b, hiz_a, hiz_b, bias_en, dout_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dual_dac_regctl uut (
      .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
      .load_n(load_n), .clear_n(clear_n), .rst_mid(rst_mid), .lock_n(lock_n),
      .code_a(code_a), .code_b(code_b), .sd_a(sd_a), .sd_b(sd_b),
      .hiz_a(hiz_a), .hiz_b(hiz_b), .bias_en(bias_en), .dout_mode(dout_mode)
   );

   // {word, code_a, code_b, sd_a, hiz_a, sd_b, hiz_b, bias_en, dout_mode}
   localparam int NV = 17;
   localparam logic [41:0] VEC [NV] = '{
      {16'h2AA8, 10'h000, 10'h000, 6'b000010},  // R2 stage A
      {16'hB550, 10'h000, 10'h000, 6'b000010},  // R2 stage B
      {16'h8000, 10'h155, 10'h2AA, 6'b000010},  // R4 update both
      {16'hF000, 10'h155, 10'h2AA, 6'b111010},  // R5 shut both
      {16'h0400, 10'h155, 10'h2AA, 6'b011010},  // R4 wake A only
      {16'h1400, 10'h155, 10'h2AA, 6'b010010},  // R4 wake B only
      {16'h5FF8, 10'h3FF, 10'h2AA, 6'b010010},  // R3 write A, update
      {16'hC008, 10'h3FF, 10'h001, 6'b010010},  // R3 write B, update
      {16'h7000, 10'h200, 10'h200, 6'b010010},  // R3 write all
      {16'h0E00, 10'h200, 10'h200, 6'b111000},  // R6 full power-down
      {16'h1800, 10'h200, 10'h200, 6'b101000},  // R5 shut A low-Z
      {16'h0400, 10'h200, 10'h200, 6'b001010},  // R6 wake A, bias on
      {16'h1D00, 10'h200, 10'h200, 6'b001110},  // R5 shut B high-Z
      {16'h1200, 10'h200, 10'h200, 6'b001111},  // R7 mode 1
      {16'h1000, 10'h200, 10'h200, 6'b001110},  // R7 mode 0
      {16'h6551, 10'h200, 10'h200, 6'b001110},  // R1 tail set: ignored
      {16'h2780, 10'h200, 10'h200, 6'b001110}   // R2 stage A again
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      cmd_word  = w;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 code_a", 32'(code_a), 32'h000);
      check("R11 code_b", 32'(code_b), 32'h000);
      check("R11 flags", 32'({sd_a, sd_b, bias_en, dout_mode}), 32'b0010);

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][41:26]);
         check($sformatf("vec%0d code_a", i), 32'(code_a), 32'(VEC[i][25:16]));
         check($sformatf("vec%0d code_b", i), 32'(code_b), 32'(VEC[i][15:6]));
         check($sformatf("vec%0d flags", i),
               32'({sd_a, hiz_a, sd_b, hiz_b, bias_en, dout_mode}), 32'(VEC[i][5:0]));
      end

      // R9 level load: live code follows staging before a clock edge
      @(negedge clk);
      load_n = 1'b0;
      #1;
      check("R9 bypass code_a", 32'(code_a), 32'h0F0);
      @(negedge clk);
      check("R9 shut channel stays shut", 32'(sd_b), 32'd1);
      // R9 coincident staging write while load_n low
      cmd_word  = 16'hA888;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      load_n    = 1'b1;
      #1;
      check("R9 coincident code_b", 32'(code_b), 32'h111);
      check("R9 code_a kept", 32'(code_a), 32'h0F0);
      check("R9 sd_b kept", 32'(sd_b), 32'd1);

      // R10 lockout falling edge wakes, codes kept
      @(negedge clk);
      lock_n = 1'b0;
      @(negedge clk);
      check("R10 wake sd_b", 32'(sd_b), 32'd0);
      check("R10 code_b kept", 32'(code_b), 32'h111);
      send(16'hF000);
      check("R10 shut ignored", 32'({sd_a, sd_b}), 32'd0);
      send(16'h0E00);
      check("R10 power-down ignored", 32'({sd_a, sd_b, bias_en}), 32'b001);
      @(negedge clk);
      lock_n = 1'b1;

      // R8 clear to midscale without clock edge
      @(negedge clk);
      rst_mid = 1'b1;
      #2;
      clear_n = 1'b0;
      #1;
      check("R8 clear mid code_a", 32'(code_a), 32'h200);
      check("R8 clear mid code_b", 32'(code_b), 32'h200);
      repeat (2) @(negedge clk);
      clear_n = 1'b1;
      send(16'h8000);
      check("R8 staging cleared", 32'({code_a, code_b}), 32'({10'h200, 10'h200}));
      check("R8 flags untouched", 32'({sd_a, sd_b, bias_en}), 32'b001);
      @(negedge clk);
      rst_mid = 1'b0;
      #2;
      clear_n = 1'b0;
      #1;
      check("R8 clear zero", 32'({code_a, code_b}), 32'd0);
      @(negedge clk);
      clear_n = 1'b1;

      // R11 reset with midscale selected; mode returns to 0
      send(16'h1200);
      check("R7 mode set", 32'(dout_mode), 32'd1);
      @(negedge clk);
      rst_mid = 1'b1;
      #2;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 mid reset codes", 32'({code_a, code_b}), 32'({10'h200, 10'h200}));
      check("R11 mode cleared", 32'({dout_mode, bias_en, sd_a, sd_b}), 32'b0100);

      finish_run();
   end
endmodule